// File: doc/BRIEF.md
# March-Algorithm Memory Self-Test Controller

This block is a self-test sequencer for a single-port synchronous RAM. After a start request it steps through one of three March tests and sends the RAM one access per clock: a word address, a write enable and a data word. Every read result is compared against the value the algorithm expects in that cell. At the end it reports pass or fail. On a failure it also gives the address, and the index of the March element, where the first mismatch was found.

Each March element has an address order and an ordered list of read and write operations. All the operations of an element are applied to one address before the engine moves to the next address. Every write and every expected read value is either all zeros or all ones across the whole data word.

The tested window is set by a lower and an upper word address. Both are captured at start, so a sub-range of the memory can be tested. The RAM answers a read one cycle after it is issued, so the compare runs one cycle behind the access stream.

Top module: `membist_march`

## Requirements
- R1: While reset is low, and after its release until the first start, busy, done, fail and mem_en are low.
- R2: start is taken only when the engine is idle (busy and done both low). A start pulse during a run has no effect on the access stream or on the run length.
- R3: busy rises in the cycle after start is taken and stays high until done rises; busy and done are never high together. A fault-free run keeps busy high for (operations per address) x (words in window) + 1 cycles.
- R4: done is high for exactly one cycle. In the cycle after it, busy and done are both low and the engine is idle.
- R5: algo selects the test: 0 = MATS++ {w0; up(r0,w1,r1); down(r1,w0,r0)}; 1 = March C- {w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); r0}; 2 = March B {w0; up(r0,w1,r1,w0,r0,w1); up(r1,w0,w1); down(r1,w0,w1,w0); down(r0,w1,w0)}; 3 behaves as 0. The access stream follows the selected list exactly, one access per cycle.
- R6: Within an element, all of its operations are applied to one address before the next address. Up elements run from first_addr to last_addr, down elements from last_addr to first_addr, and elements without a direction run upward.
- R7: A write of 1 drives all data bits high and a write of 0 drives them all low. A read passes only when every data bit equals the expected value.
- R8: Only addresses from first_addr to last_addr (inclusive, first_addr <= last_addr) are accessed. A fault outside that window does not cause a fail.
- R9: On the first read mismatch, the engine issues no further access. In the next cycle fail and done rise together, and fail_addr holds the address of the failing read. fail stays high until the next start is taken.
- R10: A taken start clears fail. A run on a fault-free memory ends with fail low.
- R11: fail_elem gives the 0-based position of the failing element in the selected list. An injected stuck-at-0 bit, a 0-to-1 transition fault, and (under March B) two linked inversion coupling faults on one victim are all reported at the first read that exposes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a test (taken only when idle) |
| algo | input | 2 | Test select: 0 MATS++, 1 March C-, 2 March B, 3 as 0 |
| first_addr | input | ADDR_W | Lowest tested word address |
| last_addr | input | ADDR_W | Highest tested word address |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first failing read |
| fail_elem | output | 3 | Element index of the first failing read |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. This makes the whole 16-word memory small enough that every test, over the full range and over a sub-range, can be compared access by access against a stream the bench expands from the element lists. The eight-bit word keeps single-bit stuck, transition and coupling faults easy to place. The expected run length, failing address and failing element are derived from the position of the first exposing read in that expanded stream.

// File: rtl/membist_march_pkg.sv
package membist_march_pkg;

   localparam int ELEM_W   = 3;
   localparam int OPI_W    = 3;
   localparam int MAX_OPS  = 6;

   localparam logic [1:0] ALG_MATSPP = 2'd0;
   localparam logic [1:0] ALG_MARCHC = 2'd1;
   localparam logic [1:0] ALG_MARCHB = 2'd2;

   // One March element: order, operation count, per-op write flag and data bit.
   typedef struct packed {
      logic                down;
      logic [OPI_W-1:0]    nops;
      logic [MAX_OPS-1:0]  wr;
      logic [MAX_OPS-1:0]  val;
   } elem_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_FIN   = 2'd3
   } state_t;

   function automatic elem_t mk(input logic d, input logic [OPI_W-1:0] n,
                                input logic [MAX_OPS-1:0] w, input logic [MAX_OPS-1:0] v);
      elem_t e;
      e.down = d;
      e.nops = n;
      e.wr   = w;
      e.val  = v;
      return e;
   endfunction

   function automatic logic [ELEM_W-1:0] elem_count(input logic [1:0] a);
      case (a)
         ALG_MARCHC: return 3'd6;
         ALG_MARCHB: return 3'd5;
         default:    return 3'd3;
      endcase
   endfunction

   // Bit k of wr/val describes operation k of the element (k = 0 first).
   function automatic elem_t elem_lookup(input logic [1:0] a, input logic [ELEM_W-1:0] i);
      elem_t e;
      e = mk(1'b0, 3'd1, 6'b000001, 6'b000000);
      case (a)
         ALG_MARCHC: begin
            case (i)
               3'd1: e = mk(1'b0, 3'd2, 6'b000010, 6'b000010);
               3'd2: e = mk(1'b0, 3'd2, 6'b000010, 6'b000001);
               3'd3: e = mk(1'b1, 3'd2, 6'b000010, 6'b000010);
               3'd4: e = mk(1'b1, 3'd2, 6'b000010, 6'b000001);
               3'd5: e = mk(1'b0, 3'd1, 6'b000000, 6'b000000);
               default: e = mk(1'b0, 3'd1, 6'b000001, 6'b000000);
            endcase
         end
         ALG_MARCHB: begin
            case (i)
               3'd1: e = mk(1'b0, 3'd6, 6'b101010, 6'b100110);
               3'd2: e = mk(1'b0, 3'd3, 6'b000110, 6'b000101);
               3'd3: e = mk(1'b1, 3'd4, 6'b001110, 6'b000101);
               3'd4: e = mk(1'b1, 3'd3, 6'b000110, 6'b000010);
               default: e = mk(1'b0, 3'd1, 6'b000001, 6'b000000);
            endcase
         end
         default: begin
            case (i)
               3'd1: e = mk(1'b0, 3'd3, 6'b000010, 6'b000110);
               3'd2: e = mk(1'b1, 3'd3, 6'b000010, 6'b000001);
               default: e = mk(1'b0, 3'd1, 6'b000001, 6'b000000);
            endcase
         end
      endcase
      return e;
   endfunction

endpackage

// File: rtl/membist_march_rom.sv
module membist_march_rom
   import membist_march_pkg::*;
(
   input  logic [1:0]        algo,
   input  logic [ELEM_W-1:0] idx,
   output elem_t             desc,
   output logic              is_last
);
   always_comb begin
      desc    = elem_lookup(algo, idx);
      is_last = (idx == elem_count(algo) - 3'd1);
   end
endmodule

// File: rtl/membist_march_seq.sv
module membist_march_seq
   import membist_march_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        algo,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              halt,
   output logic              accept,
   output logic              issue,
   output logic              op_we,
   output logic              op_val,
   output logic [ADDR_W-1:0] addr,
   output logic [ELEM_W-1:0] elem,
   output logic              busy,
   output logic              done
);
   localparam int NLOOK = 2;

   state_t            st_q;
   logic [1:0]        algo_q;
   logic [ADDR_W-1:0] lo_q, hi_q, addr_q;
   logic [ELEM_W-1:0] elem_q;
   logic [OPI_W-1:0]  op_q;

   elem_t desc   [NLOOK];
   logic  islast [NLOOK];

   // Lookup 0 describes the running element, lookup 1 the one after it.
   for (genvar g = 0; g < NLOOK; g++) begin : g_look
      membist_march_rom u_rom (
         .algo    (algo_q),
         .idx     (elem_q + ELEM_W'(g)),
         .desc    (desc[g]),
         .is_last (islast[g])
      );
   end

   logic last_op, at_end;

   always_comb begin
      last_op = (op_q == desc[0].nops - 3'd1);
      at_end  = desc[0].down ? (addr_q == lo_q) : (addr_q == hi_q);
      accept  = start && (st_q == ST_IDLE);
      issue   = (st_q == ST_RUN) && !halt;
      op_we   = desc[0].wr[op_q];
      op_val  = desc[0].val[op_q];
      addr    = addr_q;
      elem    = elem_q;
      busy    = (st_q == ST_RUN) || (st_q == ST_DRAIN);
      done    = (st_q == ST_FIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         algo_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         addr_q <= '0;
         elem_q <= '0;
         op_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  st_q   <= ST_RUN;
                  algo_q <= algo;
                  lo_q   <= first_addr;
                  hi_q   <= last_addr;
                  addr_q <= first_addr;
                  elem_q <= '0;
                  op_q   <= '0;
               end
            end
            ST_RUN: begin
               if (halt) begin
                  st_q <= ST_FIN;
               end else if (!last_op) begin
                  op_q <= op_q + 3'd1;
               end else if (!at_end) begin
                  op_q   <= '0;
                  addr_q <= desc[0].down ? addr_q - 1'b1 : addr_q + 1'b1;
               end else if (islast[0]) begin
                  st_q <= ST_DRAIN;
               end else begin
                  op_q   <= '0;
                  elem_q <= elem_q + 3'd1;
                  addr_q <= desc[1].down ? hi_q : lo_q;
               end
            end
            ST_DRAIN: st_q <= ST_FIN;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/membist_march_cmp.sv
module membist_march_cmp
   import membist_march_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_issue,
   input  logic              rd_exp,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ELEM_W-1:0] rd_elem,
   input  logic [DATA_W-1:0] rdata,
   output logic              mismatch,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [ELEM_W-1:0] fail_elem
);
   // Tags travel one stage so they line up with the RAM's read latency.
   logic              pv_q, pexp_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [ELEM_W-1:0] pelem_q;

   assign mismatch = pv_q && (rdata != {DATA_W{pexp_q}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q      <= 1'b0;
         pexp_q    <= 1'b0;
         paddr_q   <= '0;
         pelem_q   <= '0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
      end else begin
         pv_q    <= rd_issue && !clear;
         pexp_q  <= rd_exp;
         paddr_q <= rd_addr;
         pelem_q <= rd_elem;
         if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
         end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= paddr_q;
            fail_elem <= pelem_q;
         end
      end
   end
endmodule

// File: rtl/membist_march.sv
module membist_march
   import membist_march_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        algo,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_aw
      $error("membist_march: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("membist_march: DATA_W must be positive");
   end

   logic              accept, issue, op_we, op_val, halt;
   logic [ADDR_W-1:0] addr;
   logic [ELEM_W-1:0] elem;

   membist_march_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .algo       (algo),
      .first_addr (first_addr),
      .last_addr  (last_addr),
      .halt       (halt),
      .accept     (accept),
      .issue      (issue),
      .op_we      (op_we),
      .op_val     (op_val),
      .addr       (addr),
      .elem       (elem),
      .busy       (busy),
      .done       (done)
   );

   membist_march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .rd_issue  (issue && !op_we),
      .rd_exp    (op_val),
      .rd_addr   (addr),
      .rd_elem   (elem),
      .rdata     (mem_rdata),
      .mismatch  (halt),
      .fail      (fail),
      .fail_addr (fail_addr),
      .fail_elem (fail_elem)
   );

   assign mem_en    = issue;
   assign mem_we    = issue && op_we;
   assign mem_addr  = addr;
   assign mem_wdata = {DATA_W{op_val}};
endmodule

// File: rtl/membist_march_props.sv
module membist_march_props #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        algo,
   input logic [ADDR_W-1:0] first_addr,
   input logic [ADDR_W-1:0] last_addr,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [2:0]        fail_elem,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);
   logic              idle, win_ok;
   logic [ADDR_W-1:0] win_lo, win_hi;

   assign idle = !busy && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_ok <= 1'b0;
         win_lo <= '0;
         win_hi <= '0;
      end else if (start && idle) begin
         win_ok <= 1'b1;
         win_lo <= first_addr;
         win_hi <= last_addr;
      end
   end

   a_r3_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));
   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);
   a_r7_solid_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));
   a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && win_ok) |-> (mem_addr >= win_lo && mem_addr <= win_hi));
   a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !(start && idle)) |=> fail);
   a_r9_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (done && !mem_en));
   a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle) |=> !fail);
endmodule

bind membist_march membist_march_props #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .algo       (algo),
   .first_addr (first_addr),
   .last_addr  (last_addr),
   .busy       (busy),
   .done       (done),
   .fail       (fail),
   .fail_addr  (fail_addr),
   .fail_elem  (fail_elem),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rdata  (mem_rdata)
);

// File: tb/membist_march_test.sv
module membist_march_test;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    algo = '0;
   logic [AW-1:0] first_addr = '0, last_addr = '0;
   logic          busy, done, fail, mem_en, mem_we;
   logic [AW-1:0] fail_addr, mem_addr;
   logic [2:0]    fail_elem;
   logic [DW-1:0] mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   membist_march #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .algo(algo),
      .first_addr(first_addr), .last_addr(last_addr),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
      .fail_elem(fail_elem), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0, n_bad = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Behavioural RAM with injectable faults: 0 none, 1 stuck-at-0, 2 no 0->1, 3 linked coupling.
   logic [DW-1:0] ram [NW];
   int fmode = 0, faddr = 0, fbit = 0;

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            logic [DW-1:0] nv;
            nv = mem_wdata;
            if (fmode == 1 && int'(mem_addr) == faddr) nv[fbit] = 1'b0;
            if (fmode == 2 && int'(mem_addr) == faddr && !ram[mem_addr][fbit]) nv[fbit] = 1'b0;
            if (fmode == 3 && (mem_addr == 4'd2 || mem_addr == 4'd9) && !ram[mem_addr][0] && nv[0])
               ram[5][0] <= ~ram[5][0];
            ram[mem_addr] <= nv;
         end else begin
            mem_rdata <= ram[mem_addr];
         end
      end
   end

   // Expected access stream expanded from the element lists of R5/R6.
   int q_addr[$], q_elem[$];
   bit q_we[$], q_val[$];
   int tr_err = 0, tr_cnt = 0;

   function automatic string spec(input int a);
      case (a)
         1: return "Uw0|Ur0w1|Ur1w0|Dr0w1|Dr1w0|Ur0";
         2: return "Uw0|Ur0w1r1w0r0w1|Ur1w0w1|Dr1w0w1w0|Dr0w1w0";
         default: return "Uw0|Ur0w1r1|Dr1w0r0";
      endcase
   endfunction

   task automatic build(input int a, input int lo, input int hi);
      string s;
      int e, n;
      bit dn;
      bit ow[8];
      bit ov[8];
      s = spec(a);
      q_addr.delete(); q_elem.delete(); q_we.delete(); q_val.delete();
      e = 0; n = 0; dn = 1'b0;
      for (int i = 0; i <= s.len(); i++) begin
         if (i == s.len() || s[i] == "|") begin
            for (int k = 0; k <= hi - lo; k++) begin
               int ad;
               ad = dn ? hi - k : lo + k;
               for (int j = 0; j < n; j++) begin
                  q_addr.push_back(ad); q_elem.push_back(e);
                  q_we.push_back(ow[j]); q_val.push_back(ov[j]);
               end
            end
            e++; n = 0;
         end else if (s[i] == "U") dn = 1'b0;
         else if (s[i] == "D") dn = 1'b1;
         else begin
            ow[n] = (s[i] == "w");
            ov[n] = (s[i+1] == "1");
            n++; i++;
         end
      end
   endtask

   always @(negedge clk) begin
      if (mem_en) begin
         if (tr_cnt >= q_addr.size()) tr_err++;
         else if (int'(mem_addr) != q_addr[tr_cnt] || mem_we != q_we[tr_cnt] ||
                  (mem_we && mem_wdata != {DW{q_val[tr_cnt]}})) tr_err++;
         tr_cnt++;
      end
   end

   int bcyc;

   task automatic run(input int a, input int lo, input int hi, input int poke);
      build(a, lo, hi);
      tr_err = 0; tr_cnt = 0; bcyc = 0;
      @(negedge clk);
      start = 1'b1; algo = 2'(a); first_addr = AW'(lo); last_addr = AW'(hi);
      @(negedge clk);
      start = 1'b0; algo = '0; first_addr = '0; last_addr = '0;
      while (!done) begin
         if (busy) bcyc++;
         start = (bcyc == poke);
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic after_done(input string tag);
      check(done && !busy, {tag, " R4 done seen"}, int'(done), 1);
      @(negedge clk);
      check(!done && !busy, {tag, " R4 single pulse then idle"}, int'(done), 0);
   endtask

   task automatic clean_run(input int a, input int lo, input int hi, input int poke, input string tag);
      for (int i = 0; i < NW; i++) ram[i] = '0;
      fmode = 0;
      run(a, lo, hi, poke);
      check(bcyc == q_addr.size() + 1, {tag, " R3 busy length"}, bcyc, q_addr.size() + 1);
      check(tr_err == 0 && tr_cnt == q_addr.size(), {tag, " R5 R6 R7 access stream"}, tr_err, 0);
      check(!fail, {tag, " R10 clean pass"}, int'(fail), 0);
      after_done(tag);
   endtask

   task automatic fault_run(input int a, input int mode, input int ad, input int bt, input string tag);
      int idx;
      for (int i = 0; i < NW; i++) ram[i] = '0;
      fmode = mode; faddr = ad; fbit = bt;
      run(a, 0, NW - 1, -1);
      idx = -1;
      for (int i = 0; i < q_addr.size(); i++)
         if (idx < 0 && q_addr[i] == ad && !q_we[i] && q_val[i]) idx = i;
      check(fail, {tag, " R9 fail raised"}, int'(fail), 1);
      check(int'(fail_addr) == ad, {tag, " R9 fail_addr"}, int'(fail_addr), ad);
      check(int'(fail_elem) == q_elem[idx], {tag, " R11 fail_elem"}, int'(fail_elem), q_elem[idx]);
      check(tr_cnt == idx + 1 && tr_err == 0, {tag, " R9 stop after mismatch"}, tr_cnt, idx + 1);
      check(bcyc == idx + 2, {tag, " R3 busy on fail"}, bcyc, idx + 2);
      after_done(tag);
      check(fail, {tag, " R9 fail sticky"}, int'(fail), 1);
      fmode = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) ram[i] = '0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_en, "R1 in reset", int'(busy | done | fail | mem_en), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !fail && !mem_en, "R1 after reset", int'(busy | done | fail | mem_en), 0);

      clean_run(0, 0, NW - 1, -1, "mats full");
      clean_run(1, 0, NW - 1, -1, "marchc full");
      clean_run(2, 0, NW - 1, -1, "marchb full");
      clean_run(3, 0, NW - 1, -1, "R5 code3 as mats");
      clean_run(1, 3, 11, -1, "R8 marchc subrange");
      clean_run(0, 6, 6, -1, "R8 single word");
      clean_run(2, 0, NW - 1, 20, "R2 start while busy");

      for (int a = 0; a < 3; a++) begin
         fault_run(a, 1, 7, 3, $sformatf("R11 stuck0 algo%0d", a));
         clean_run(a, 0, NW - 1, -1, $sformatf("R10 clear after fail algo%0d", a));
         fault_run(a, 2, 12, 0, $sformatf("R11 trans01 algo%0d", a));
      end

      // Stuck bit outside the window must not be reported.
      for (int i = 0; i < NW; i++) ram[i] = '0;
      fmode = 1; faddr = 1; fbit = 5;
      run(2, 4, 10, -1);
      check(!fail && tr_err == 0, "R8 fault outside window ignored", int'(fail), 0);
      after_done("R8 outside");
      fmode = 0;

      // Two aggressors (2 and 9) each invert bit 0 of victim 5 on a 0->1 write.
      for (int i = 0; i < NW; i++) ram[i] = '0;
      fmode = 3;
      run(2, 0, NW - 1, -1);
      check(fail, "R11 linked coupling detected", int'(fail), 1);
      check(fail_addr == 4'd5, "R11 linked coupling addr", int'(fail_addr), 5);
      check(fail_elem == 3'd2, "R11 linked coupling elem", int'(fail_elem), 2);
      after_done("R11 coupling");
      fmode = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule